// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block carries an 18-bit word each way between two buses, side A and side B. Each direction has its own four controls: an active-low drive enable, a flow-through select, a capture clock and an active-low capture-clock enable. With flow-through selected, the destination side shows the source word with no delay. With flow-through off, the path shows a stored word. That word is loaded on rising edges of the path's capture clock, but only while the capture enable is asserted. The drive enable only decides whether the destination pins are driven. It never touches what is stored or what is shown.

The pads are split for synthesis. Each side has an input bus, an output bus and a one-bit drive flag, and a pad ring or testbench resolves them into a tri-state bus. The block runs on a single system clock. The path capture clocks are sampled as ordinary inputs, and a rising edge is seen at the first system-clock edge where the sampled level is high after having been low. An optional synchronizer depth parameter adds flops ahead of that edge detector. An asynchronous active-high reset clears both stored words and holds both drive flags low.

Top module: `xbus_transceiver`

## Requirements
- R1: Both directions carry WIDTH (default 18) bits without inversion. Each uses only its own four controls, so activity on one direction's controls never changes the other direction's output or stored word.
- R2: Outside reset, a destination drive flag (`b_drv` for A-to-B, `a_drv` for B-to-A) is 1 when that path's drive enable input is 0, and 0 when it is 1.
- R3: With the flow-through select at 1, the destination output equals the source input in the same cycle, with no system-clock edge needed.
- R4: With flow-through at 0 and capture enable at 0, a rising edge of the path clock loads the source word. A rising edge is a system-clock edge at which the clock input is 1 after it was 0 at the previous edge. The destination output shows the loaded word after that system-clock edge.
- R5: With flow-through at 0 and the path clock held steady at 1 or at 0, the output keeps the stored word while the source input changes.
- R6: With flow-through at 0 and capture enable at 1, rising edges of the path clock are ignored and the stored word is kept.
- R7: While reset is 1, both stored words are 0 and both drive flags are 0, whatever the drive enables are.
- R8: When flow-through drops to 0, the stored word is the source word present at the last system-clock edge at which flow-through was 1.
- R9: A falling edge of the path clock loads nothing.
- R10: The destination data output carries the path's value whatever the drive enable is. The drive enable changes only the drive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| a_in | input | 18 | Side A pad input (source of A-to-B) |
| a_out | output | 18 | Side A pad output (destination of B-to-A) |
| a_drv | output | 1 | Side A drive flag |
| b_in | input | 18 | Side B pad input (source of B-to-A) |
| b_out | output | 18 | Side B pad output (destination of A-to-B) |
| b_drv | output | 1 | Side B drive flag |
| ab_drv_n | input | 1 | A-to-B drive enable, active low |
| ab_flow | input | 1 | A-to-B flow-through select |
| ab_cap_ck | input | 1 | A-to-B capture clock |
| ab_cap_en_n | input | 1 | A-to-B capture-clock enable, active low |
| ba_drv_n | input | 1 | B-to-A drive enable, active low |
| ba_flow | input | 1 | B-to-A flow-through select |
| ba_cap_ck | input | 1 | B-to-A capture clock |
| ba_cap_en_n | input | 1 | B-to-A capture-clock enable, active low |

## Verification
Flow-through is tried by changing the source word with no clock edge. This separates a combinational path from one that passes through a register. Registered mode gets alternating and walking patterns, each followed by a steady-high clock, a falling clock and a disabled enable. A design that captures on levels, on either edge, or whatever the enable says will show a stale or early word. Dropping flow-through while the source changes in the same cycle shows whether the held word is the last one that flowed or the new one. Both directions run at once with different words to show that their controls are independent.

// File: rtl/xbt_pkg.sv
package xbt_pkg;
   localparam int NUM_DIR = 2;
   localparam int DIR_AB  = 0;
   localparam int DIR_BA  = 1;

   typedef struct packed {
      logic drv_n;
      logic flow;
      logic cap_ck;
      logic cap_en_n;
   } xbt_ctl_t;
endpackage

// File: rtl/xbt_edge_detect.sv
module xbt_edge_detect #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic ck_in,
   output logic rise
);
   localparam int MAX_STAGES = 3;

   if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_STAGES) begin : g_bad_stages
      $error("xbt_edge_detect: SYNC_STAGES out of range");
   end

   logic ck_s;
   logic ck_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign ck_s = ck_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or posedge rst) begin
         if (rst) sh <= '0;
         else     sh <= {sh[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], ck_in};
      end
      assign ck_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) ck_q <= 1'b0;
      else     ck_q <= ck_s;
   end

   assign rise = ck_s & ~ck_q;
endmodule

// File: rtl/xbt_path.sv
module xbt_path
   import xbt_pkg::*;
#(
   parameter int WIDTH       = 18,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] src,
   input  xbt_ctl_t         ctl,
   output logic [WIDTH-1:0] dst,
   output logic             dst_drv
);
   if (WIDTH < 1) begin : g_bad_width
      $error("xbt_path: WIDTH must be at least 1");
   end

   logic             ck_rise;
   logic [WIDTH-1:0] store;
   logic             load;

   xbt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .ck_in (ctl.cap_ck),
      .rise  (ck_rise)
   );

   // Shared storage: tracks while flowing, otherwise gated edge register.
   assign load = ctl.flow | (~ctl.cap_en_n & ck_rise);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       store <= '0;
      else if (load) store <= src;
   end

   assign dst     = ctl.flow ? src : store;
   assign dst_drv = ~ctl.drv_n & ~rst;

   // R4: a gated rising edge loads the source word
   p_capture_r4: assert property (@(posedge clk) disable iff (rst)
      (!ctl.flow && !ctl.cap_en_n && ck_rise) |=> (store == $past(src)));

   // R5, R6, R9: no enabled rising edge means the word is kept
   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!ctl.flow && (ctl.cap_en_n || !ck_rise)) |=> $stable(store));

   // R8: while flowing, storage follows so a drop keeps the last word
   p_flow_track_r8: assert property (@(posedge clk) disable iff (rst)
      ctl.flow |=> (store == $past(src)));

   // R7: reset clears storage and the drive flag
   p_reset_r7: assert property (@(posedge clk)
      rst |-> (store == '0 && !dst_drv));

   // R3: flow-through shows the source without delay
   p_flow_r3: assert property (@(posedge clk) disable iff (rst)
      ctl.flow |-> (dst == src));
endmodule

// File: rtl/xbus_transceiver.sv
module xbus_transceiver
   import xbt_pkg::*;
#(
   parameter int WIDTH       = 18,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drv,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drv,
   input  logic             ab_drv_n,
   input  logic             ab_flow,
   input  logic             ab_cap_ck,
   input  logic             ab_cap_en_n,
   input  logic             ba_drv_n,
   input  logic             ba_flow,
   input  logic             ba_cap_ck,
   input  logic             ba_cap_en_n
);
   logic [WIDTH-1:0] src_w [NUM_DIR];
   logic [WIDTH-1:0] dst_w [NUM_DIR];
   logic             drv_w [NUM_DIR];
   xbt_ctl_t         ctl_w [NUM_DIR];

   assign src_w[DIR_AB] = a_in;
   assign src_w[DIR_BA] = b_in;
   assign ctl_w[DIR_AB] = '{drv_n: ab_drv_n, flow: ab_flow, cap_ck: ab_cap_ck, cap_en_n: ab_cap_en_n};
   assign ctl_w[DIR_BA] = '{drv_n: ba_drv_n, flow: ba_flow, cap_ck: ba_cap_ck, cap_en_n: ba_cap_en_n};

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      xbt_path #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_path (
         .clk     (clk),
         .rst     (rst),
         .src     (src_w[d]),
         .ctl     (ctl_w[d]),
         .dst     (dst_w[d]),
         .dst_drv (drv_w[d])
      );
   end

   assign b_out = dst_w[DIR_AB];
   assign b_drv = drv_w[DIR_AB];
   assign a_out = dst_w[DIR_BA];
   assign a_drv = drv_w[DIR_BA];

   // R2: a high drive enable keeps the destination undriven
   p_drive_off_r2: assert property (@(posedge clk) disable iff (rst)
      (ab_drv_n |-> !b_drv) and (ba_drv_n |-> !a_drv));

   // R2: a low drive enable drives the destination
   p_drive_on_r2: assert property (@(posedge clk) disable iff (rst)
      (!ab_drv_n |-> b_drv) and (!ba_drv_n |-> a_drv));
endmodule

// File: tb/xbus_transceiver_bench.sv
module xbus_transceiver_bench;
   localparam int W = 18;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic a_drv, b_drv;
   logic ab_drv_n = 1'b0, ab_flow = 1'b0, ab_cap_ck = 1'b0, ab_cap_en_n = 1'b0;
   logic ba_drv_n = 1'b0, ba_flow = 1'b0, ba_cap_ck = 1'b0, ba_cap_en_n = 1'b0;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   xbus_transceiver u_xbus_transceiver (
      .clk(clk), .rst(rst),
      .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
      .ab_drv_n(ab_drv_n), .ab_flow(ab_flow), .ab_cap_ck(ab_cap_ck), .ab_cap_en_n(ab_cap_en_n),
      .ba_drv_n(ba_drv_n), .ba_flow(ba_flow), .ba_cap_ck(ba_cap_ck), .ba_cap_en_n(ba_cap_en_n)
   );

   task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one system-clock edge, then back to the middle of the low phase
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(W'(a_drv), W'(0), "R7 a_drv in reset");
      chk(W'(b_drv), W'(0), "R7 b_drv in reset");
      chk(b_out, '0, "R7 A-to-B word cleared");
      chk(a_out, '0, "R7 B-to-A word cleared");
      rst = 1'b0;
      step();
      chk(W'(b_drv), W'(1), "R2 b_drv on after reset");
   endtask

   task automatic t_drive();
      ab_flow = 1'b0; a_in = 18'h2A5A5;
      ab_drv_n = 1'b1; #1;
      chk(W'(b_drv), W'(0), "R2 b_drv off");
      chk(W'(a_drv), W'(1), "R1 a_drv unaffected by A-to-B enable");
      ab_flow = 1'b1; #1;
      chk(b_out, 18'h2A5A5, "R10 data present while undriven");
      ba_drv_n = 1'b1; #1;
      chk(W'(a_drv), W'(0), "R2 a_drv off");
      ab_drv_n = 1'b0; ba_drv_n = 1'b0; #1;
      chk(W'(b_drv), W'(1), "R2 b_drv on");
      step();
   endtask

   task automatic t_flow();
      ab_flow = 1'b1;
      a_in = 18'h15555; #1;
      chk(b_out, 18'h15555, "R3 flow pattern 1");
      a_in = 18'h0F0F0; #1;
      chk(b_out, 18'h0F0F0, "R3 flow pattern 2 no clock edge");
      step();
   endtask

   task automatic t_le_fall();
      ab_flow = 1'b1; a_in = 18'h12345;
      step();
      ab_flow = 1'b0; a_in = 18'h3FFFF; #1;
      chk(b_out, 18'h12345, "R8 flow drop keeps last flowed word");
      step();
      chk(b_out, 18'h12345, "R8 still held next cycle");
   endtask

   task automatic t_edge();
      ab_flow = 1'b0; ab_cap_en_n = 1'b0; ab_cap_ck = 1'b0;
      step();
      for (int i = 0; i < 4; i++) begin
         logic [W-1:0] v;
         v = W'(18'h1 << (i * 5)) ^ 18'h2AAAA;
         a_in = v; ab_cap_ck = 1'b1;
         step();
         chk(b_out, v, "R4 rising edge capture");
         a_in = ~v;
         step();
         chk(b_out, v, "R5 clock steady high holds");
         ab_cap_ck = 1'b0;
         step();
         chk(b_out, v, "R9 falling edge loads nothing");
         step();
         chk(b_out, v, "R5 clock steady low holds");
      end
   endtask

   task automatic t_ce();
      ab_flow = 1'b0; ab_cap_ck = 1'b0; ab_cap_en_n = 1'b0; a_in = 18'h00111;
      step();
      ab_cap_ck = 1'b1;
      step();
      chk(b_out, 18'h00111, "R4 capture before disable");
      ab_cap_ck = 1'b0; ab_cap_en_n = 1'b1; a_in = 18'h3C3C3;
      step();
      ab_cap_ck = 1'b1;
      step();
      chk(b_out, 18'h00111, "R6 disabled edge ignored");
      ab_cap_ck = 1'b0; ab_cap_en_n = 1'b0;
      step();
      ab_cap_ck = 1'b1;
      step();
      chk(b_out, 18'h3C3C3, "R4 capture after re-enable");
      ab_cap_ck = 1'b0;
      step();
   endtask

   task automatic t_both();
      ab_flow = 1'b0; ba_flow = 1'b0; ab_cap_ck = 1'b0; ba_cap_ck = 1'b0;
      ab_cap_en_n = 1'b0; ba_cap_en_n = 1'b0;
      a_in = 18'h0AAAA; b_in = 18'h35555;
      step();
      ba_cap_ck = 1'b1;
      step();
      chk(a_out, 18'h35555, "R1 B-to-A capture");
      chk(b_out, 18'h3C3C3, "R1 A-to-B untouched by B-to-A clock");
      ba_flow = 1'b1; b_in = 18'h00F00; #1;
      chk(a_out, 18'h00F00, "R3 B-to-A flow");
      chk(b_out, 18'h3C3C3, "R1 A-to-B untouched by B-to-A flow");
      ab_cap_ck = 1'b1;
      step();
      chk(b_out, 18'h0AAAA, "R4 A-to-B capture with B-to-A flowing");
      ba_flow = 1'b0; ab_cap_ck = 1'b0; ba_cap_ck = 1'b0;
      step();
   endtask

   task automatic t_mid_reset();
      #1 rst = 1'b1; #1;
      chk(b_out, '0, "R7 async reset clears A-to-B word");
      chk(a_out, '0, "R7 async reset clears B-to-A word");
      chk(W'(b_drv), W'(0), "R7 drive flag low in reset");
      @(negedge clk);
      rst = 1'b0;
      step();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_drive();
      t_flow();
      t_le_fall();
      t_edge();
      t_ce();
      t_both();
      t_mid_reset();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule